// File: doc/BRIEF.md
# Transition-Triggered One-Shot Bit Clock Recovery

This block pulls a bit clock out of a serial NRZ stream without any phase or frequency loop. It runs from a fast sampling clock at a fixed multiple of the bit rate, 100 times by default. A one-cycle delay stage compares each data sample with the one before it, so every rising or falling data transition produces a pulse one fast cycle wide. That pulse fires a counter-based one-shot. The one-shot's output is the active-low form of the recovered clock, and `rclk` is simply its inverse.

When the stream has a run of equal bits, the one-shot restarts itself from its own end-of-gap feedback, so the clock keeps its bit period. A data edge always wins over this feedback. The rising edge of `rclk` comes when the timed pulse ends, which is half a bit after the trigger. On that edge a decision register samples the data and holds the bit for a full period.

The one-shot is a three-state machine:
- `ST_IDLE`: the stable state after reset, with the output low and `rclk` high.
- `ST_TIMED`: the timed state, with the output high for `HOLD_CYC` cycles.
- `ST_GAP`: the output is low while the machine counts `GAP_CYC` cycles toward its self-retrigger.

Its transitions are:
- FIRE: from any state to `ST_TIMED` on an edge pulse, with the counter cleared.
- EXPIRE: from `ST_TIMED` to `ST_GAP` at the last timed cycle. This is the moment the data is sampled.
- SELF: from `ST_GAP` to `ST_TIMED` at the last gap cycle.
- RESET: to `ST_IDLE`.

Top module: `mono_cdr`

## Requirements
- R1: `edge_stb` is high in exactly those fast cycles in which `din` differs from its value at the previous fast-clock edge. Each data transition therefore gives a single one-cycle strobe.
- R2: After a trigger edge, `rclk` is low for exactly `HOLD_CYC` (default 50) fast cycles and then goes high.
- R3: With no further data edges, the one-shot retriggers itself `GAP_CYC` (default 50) cycles after its pulse ends. `rclk` then repeats low for 50 cycles and high for 50 cycles, a period of 100.
- R4: An edge pulse in any state, including the timed state, restarts the timed state with the count at zero. An edge pulse in the same cycle as expiry or self-retrigger takes priority over both.
- R5: `rclk` is the inverse of the one-shot output with no further phase stage. After reset it stays high until the first data edge.
- R6: `dout` loads the `din` value at the fast-clock edge where `rclk` rises, which is `HOLD_CYC` cycles after the trigger. It holds that value at every other edge.
- R7: While reset is high, the one-shot is in `ST_IDLE` (`rclk` high), `dout` is 0 and the delay register is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock, `OVERSAMPLE` times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | NRZ data, already synchronous to `clk` |
| rclk | output | 1 | Recovered bit clock (inverse of the one-shot output) |
| dout | output | 1 | Retimed data |
| edge_stb | output | 1 | One-cycle data transition strobe |

## Verification
The assertions assume that `din` is already synchronous to `clk` and changes at most once per fast cycle. They also assume that reset is held for at least one edge. The bench changes `din` and `rst` only just after falling clock edges, which keeps it within these assumptions. It drives `din` low before asserting reset, so the cleared delay register never produces a stray strobe afterwards. The random bit lengths jitter around 100 cycles and include long runs of equal bits. Directed bits place edges in the timed state, at expiry, at self-retrigger and one cycle apart.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    // One-shot machine states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TIMED = 2'd1,
        ST_GAP   = 2'd2
    } os_state_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mcr_edge_pulser.sv
module mcr_edge_pulser (
    input  logic clk,
    input  logic rst,
    input  logic din_i,
    output logic edge_o
);

    logic din_q;

    // one fast-cycle delay of the data
    always_ff @(posedge clk) begin
        if (rst) begin
            din_q <= 1'b0;
        end else begin
            din_q <= din_i;
        end
    end

    // pulse while the live sample differs from the delayed one
    assign edge_o = din_i ^ din_q;

endmodule

// File: rtl/mcr_one_shot.sv
module mcr_one_shot
    import mcr_pkg::*;
#(
    parameter int HOLD_CYC = 50,
    parameter int GAP_CYC  = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic pulse_o,
    output logic expire_o
);

    localparam int CNT_MAX = max_int(HOLD_CYC, GAP_CYC);
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_CYC - 1);

    os_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: FIRE beats EXPIRE and SELF
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (trig_i) begin
            state_d = ST_TIMED;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
                ST_TIMED: begin
                    if (cnt_q == HOLD_LAST) begin
                        state_d = ST_GAP;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_GAP: begin
                    if (cnt_q == GAP_LAST) begin
                        state_d = ST_TIMED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        pulse_o  = 1'b0;
        expire_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  pulse_o = 1'b0;
            ST_TIMED: begin
                pulse_o  = 1'b1;
                expire_o = (cnt_q == HOLD_LAST) && !trig_i;
            end
            ST_GAP:   pulse_o = 1'b0;
            default:  pulse_o = 1'b0;
        endcase
    end

    AST_FIRE_RESTART: assert property (@(posedge clk) disable iff (rst)
        trig_i |=> (state_q == ST_TIMED && cnt_q == '0)); // R4
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TIMED) |-> (cnt_q <= HOLD_LAST)); // R2
    AST_TIMED_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_o) |-> ($past(cnt_q) == HOLD_LAST && !$past(trig_i))); // R2
    AST_SELF_RETRIG: assert property (@(posedge clk) disable iff (rst)
        ($rose(pulse_o) && !$past(trig_i)) |->
            ($past(state_q) == ST_GAP && $past(cnt_q) == GAP_LAST)); // R3

endmodule

// File: rtl/mcr_retime.sv
module mcr_retime (
    input  logic clk,
    input  logic rst,
    input  logic smp_en_i,
    input  logic din_i,
    output logic dout_o
);

    // decision register, loaded only at the recovered clock edge
    always_ff @(posedge clk) begin
        if (rst) begin
            dout_o <= 1'b0;
        end else if (smp_en_i) begin
            dout_o <= din_i;
        end
    end

    AST_HOLD_BIT: assert property (@(posedge clk) disable iff (rst)
        !smp_en_i |=> $stable(dout_o)); // R6

endmodule

// File: rtl/mono_cdr.sv
module mono_cdr #(
    parameter int OVERSAMPLE = 100,
    parameter int HOLD_CYC   = OVERSAMPLE / 2,
    parameter int GAP_CYC    = OVERSAMPLE - HOLD_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rclk,
    output logic dout,
    output logic edge_stb
);

    logic trig;
    logic os_pulse;
    logic os_expire;

    mcr_edge_pulser u_edge (
        .clk    (clk),
        .rst    (rst),
        .din_i  (din),
        .edge_o (trig)
    );

    mcr_one_shot #(
        .HOLD_CYC (HOLD_CYC),
        .GAP_CYC  (GAP_CYC)
    ) u_oneshot (
        .clk      (clk),
        .rst      (rst),
        .trig_i   (trig),
        .pulse_o  (os_pulse),
        .expire_o (os_expire)
    );

    mcr_retime u_retime (
        .clk      (clk),
        .rst      (rst),
        .smp_en_i (os_expire),
        .din_i    (din),
        .dout_o   (dout)
    );

    assign rclk     = ~os_pulse;
    assign edge_stb = trig;

    AST_SAMPLE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(rclk) |-> $past(os_expire)); // R6
    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (rclk && !dout)); // R7

endmodule

// File: tb/mono_cdr_tb_top.sv
module mono_cdr_tb_top;

    localparam int HOLD = 50;
    localparam int PER  = 100;
    localparam int WD   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic rclk, dout, edge_stb;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 0;

    // reference state
    int   t_since = 0;
    bit   started = 0;
    logic exp_dout = 1'b0;
    logic din_prev = 1'b0;

    always #10 clk = ~clk;

    mono_cdr dut_i (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .rclk     (rclk),
        .dout     (dout),
        .edge_stb (edge_stb)
    );

    function automatic logic exp_rclk();
        if (!started) return 1'b1;
        return ((t_since % PER) >= HOLD) ? 1'b1 : 1'b0;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // reference update at a rising edge
    task automatic model_step();
        bit e;
        cyc++;
        if (rst) begin
            started  = 0;
            t_since  = 0;
            exp_dout = 1'b0;
            din_prev = 1'b0;
        end else begin
            e        = (din != din_prev);
            din_prev = din;
            if (e) begin
                started = 1;
                t_since = 0;
            end else if (started) begin
                t_since++;
                if ((t_since % PER) == HOLD) exp_dout = din;
            end
        end
    endtask

    task automatic run_cycle(input logic nd, input logic nr);
        @(negedge clk);
        chk("R2 R3 R4 R5 rclk", rclk, exp_rclk());
        chk("R6 dout", dout, exp_dout);
        din = nd;
        rst = nr;
        #1;
        chk("R1 edge_stb", edge_stb, (!nr && din != din_prev) ? 1'b1 :
            ((nr && din != din_prev) ? 1'b1 : 1'b0));
        @(posedge clk);
        model_step();
    endtask

    task automatic send(input logic b, input int len);
        for (int i = 0; i < len; i++) run_cycle(b, 1'b0);
    endtask

    task automatic do_reset();
        run_cycle(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) run_cycle(1'b0, 1'b1);
        @(negedge clk);
        chk("R7 rclk in reset", rclk, 1'b1);
        chk("R7 dout in reset", dout, 1'b0);
        chk("R7 no strobe in reset", edge_stb, 1'b0);
        run_cycle(1'b0, 1'b0);
    endtask

    initial begin
        logic b;
        int   len;
        void'($urandom(32'd4242));
        // power-on reset
        for (int i = 0; i < 4; i++) run_cycle(1'b0, 1'b1);
        @(negedge clk);
        chk("R7 rclk after reset", rclk, 1'b1);
        chk("R7 dout after reset", dout, 1'b0);
        // idle with no edges: clock stays high
        send(1'b0, 200);
        @(negedge clk);
        chk("R5 idle rclk high", rclk, 1'b1);
        // first edge then a long run: self retrigger
        send(1'b1, 450);
        // directed edges at corner times
        send(1'b0, 20);   // edge inside timed state
        send(1'b1, 50);   // edge at expiry
        send(1'b0, 49);
        send(1'b1, 51);
        send(1'b0, 100);  // edge at self retrigger
        send(1'b1, 150);
        send(1'b0, 1);    // one-cycle glitch
        send(1'b1, 1);
        send(1'b0, 300);
        // random stream
        for (int k = 0; k < 220; k++) begin
            b = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 7) == 0) len = PER * $urandom_range(2, 4);
            else len = 97 + $urandom_range(0, 6);
            send(b, len);
        end
        // mid-run reset then more traffic
        do_reset();
        for (int k = 0; k < 40; k++) begin
            b = 1'($urandom_range(0, 1));
            send(b, 95 + $urandom_range(0, 10));
        end
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule